// File: doc/BRIEF.md
# In-Place 8x8 Block Transposer

This block turns a stream of byte samples, arriving in row-major order as 8x8 blocks, into the same stream with every block transposed. It uses a single 64-entry memory with one access port. On every accepted sample it reads the location at the current address and then stores the new sample there. The address order changes after every 64 accepted samples. One block is addressed in row order, the next in column order, then row order again, and so on. Because of this, the data read out is always the transpose of the block that was stored during the previous 64 accepted samples.

A typical use is between two one-dimensional transform stages. The first stage produces rows and the second needs columns. The input side has a valid flag and a data byte. A cycle with the valid flag low is a stall: the memory, the address sequence and the scan order all stay as they are. The output side gives a data byte, a valid flag, and a marker that pulses with the first sample of each transposed block. No valid output appears until one full block has been stored since reset.

Top module: `inplace_transposer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` and `out_first` are 0. A reset in the middle of a stream returns the block to its empty state, so the next 64 accepted samples again produce no valid output.
- R2: The first 64 samples accepted after reset produce no valid output (`out_valid` stays 0).
- R3: `out_valid` is 1 in the cycle after a sample is accepted (`in_valid` = 1 at a rising edge), provided at least 64 samples had been accepted before it since reset. Otherwise `out_valid` is 0.
- R4: For an output produced by a sample with within-block index k (0 to 63) in an odd-numbered block (numbering from 0 after reset), the output data equals the input sample with index (k mod 8)*8 + (k div 8) of the previous block. This is the column-order read of a block that was stored in row order.
- R5: The relation in R4 also holds for even-numbered blocks from block 2 onward. In these blocks a block that was stored in column order is read back in row order. The two scan orders alternate without limit.
- R6: A cycle with `in_valid` = 0 advances nothing. The next cycle has `out_valid` = 0, `out_data` keeps its previous value, and later outputs are the same as if the stall had not happened.
- R7: `out_first` is 1 exactly in the cycles in which `out_valid` is 1 for a within-block index of 0. It is 0 at all other times.
- R8: All byte values, including 8'h00 and 8'hFF, pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present; low stalls the schedule |
| in_data | input | 8 | Input sample, row-major within the block |
| out_valid | output | 1 | Output sample present |
| out_data | output | 8 | Transposed output sample |
| out_first | output | 1 | Pulses with the first output sample of each transposed block |

## Verification
The hardest case to reach from the ports is a stall that falls exactly on a block boundary or the scan-order switch. If such a stall advanced the counter, or flipped the scan order, or wrote the memory, the error would only show up one full block later as a wrongly permuted block. The stimulus therefore places random stall gaps at about one cycle in four, adds a long directed stall in the middle of a block, and runs enough blocks to cover both scan orders several times. A mid-stream reset then checks that the schedule starts again from an empty state.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int TP_SIDE_LG = 3;
    localparam int TP_DATA_W  = 8;

    // Order in which the linear step counter is mapped onto the memory.
    typedef enum logic {
        SCAN_ROW = 1'b0,
        SCAN_COL = 1'b1
    } scan_e;

    // Registered status flags of the output beat.
    typedef struct packed {
        logic valid;
        logic first;
    } beat_flags_t;

    function automatic scan_e next_scan(input scan_e cur);
        return (cur == SCAN_ROW) ? SCAN_COL : SCAN_ROW;
    endfunction

endpackage

// File: rtl/tp_seq.sv
module tp_seq
    import tp_pkg::*;
#(
    parameter int SIDE_LG = TP_SIDE_LG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    output logic [2*SIDE_LG-1:0] addr,
    output logic                 primed,
    output logic                 block_start
);

    localparam int AW = 2 * SIDE_LG;
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    logic [AW-1:0] step_q;
    scan_e         scan_q;
    logic          primed_q;
    logic          wrap;

    assign wrap = (step_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= '0;
            scan_q   <= SCAN_ROW;
            primed_q <= 1'b0;
        end else if (adv) begin
            step_q <= step_q + 1'b1;
            if (wrap) begin
                scan_q   <= next_scan(scan_q);
                primed_q <= 1'b1;
            end
        end
    end

    // Column scan swaps the row and column fields of the step counter.
    always_comb begin
        if (scan_q == SCAN_COL) begin
            addr = {step_q[SIDE_LG-1:0], step_q[AW-1:SIDE_LG]};
        end else begin
            addr = step_q;
        end
    end

    assign primed      = primed_q;
    assign block_start = (step_q == '0);

    a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(step_q) && $stable(scan_q)));

    a_r5_scan_alternates: assert property (@(posedge clk) disable iff (rst)
        (adv && wrap) |=> (scan_q != $past(scan_q)));

    a_r2_primed_after_block: assert property (@(posedge clk) disable iff (rst)
        (adv && wrap) |=> primed_q);

    a_r6_step_advances: assert property (@(posedge clk) disable iff (rst)
        (adv && !wrap) |=> (step_q == $past(step_q) + 1'b1));

endmodule

// File: rtl/tp_ram.sv
module tp_ram #(
    parameter int DATA_W = 8,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // One access per step: the old content leaves, the new sample takes its place.
    always_ff @(posedge clk) begin
        if (en) begin
            rdata     <= mem[addr];
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/inplace_transposer.sv
module inplace_transposer
    import tp_pkg::*;
#(
    parameter int DATA_W  = TP_DATA_W,
    parameter int SIDE_LG = TP_SIDE_LG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first
);

    localparam int AW = 2 * SIDE_LG;

    logic [AW-1:0] ram_addr;
    logic          seq_primed;
    logic          seq_start;
    beat_flags_t   flags_q;

    tp_seq #(
        .SIDE_LG(SIDE_LG)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .adv        (in_valid),
        .addr       (ram_addr),
        .primed     (seq_primed),
        .block_start(seq_start)
    );

    tp_ram #(
        .DATA_W(DATA_W),
        .AW    (AW)
    ) ram_i (
        .clk  (clk),
        .en   (in_valid),
        .addr (ram_addr),
        .wdata(in_data),
        .rdata(out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.valid <= in_valid && seq_primed;
            flags_q.first <= in_valid && seq_primed && seq_start;
        end
    end

    assign out_valid = flags_q.valid;
    assign out_first = flags_q.first;

    a_r3_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    a_r2_quiet_until_primed: assert property (@(posedge clk) disable iff (rst)
        !seq_primed |=> !out_valid);

    a_r7_first_is_valid: assert property (@(posedge clk) disable iff (rst)
        out_first |-> out_valid);

    a_r7_first_single: assert property (@(posedge clk) disable iff (rst)
        out_first |=> !out_first);

    a_r6_data_held: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

endmodule

// File: tb/inplace_transposer_tb.sv
`timescale 1ns/1ps
module inplace_transposer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_first;

    always #2.5 clk = ~clk;

    inplace_transposer dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_first(out_first)
    );

    int checks = 0;
    int errors = 0;
    int acc = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [7:0] prev_blk [64];
    logic [7:0] cur_blk  [64];
    logic [7:0] last_out = 8'h00;

    function automatic int swp(input int k);
        return (k % 8) * 8 + (k / 8);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drives one cycle, then checks the result at the next falling edge.
    task automatic push(input logic v, input logic [7:0] d, input bit extremes);
        logic       exp_v, exp_f;
        logic [7:0] exp_d;
        int         k, blk;
        exp_v = 1'b0; exp_f = 1'b0; exp_d = last_out; k = 0; blk = 0;
        in_valid = v;
        in_data  = d;
        if (v) begin
            k   = acc % 64;
            blk = acc / 64;
            if (acc >= 64) begin
                exp_v = 1'b1;
                exp_d = prev_blk[swp(k)];
                exp_f = (k == 0);
            end
            cur_blk[k] = d;
            if (k == 63) begin
                for (int i = 0; i < 64; i++) prev_blk[i] = cur_blk[i];
            end
            acc++;
        end
        @(negedge clk);
        if (!v) begin
            chk(out_valid === 1'b0, "R6 valid after stall", out_valid, 0);
            chk(out_data === last_out, "R6 data held", out_data, last_out);
        end else if (!exp_v) begin
            chk(out_valid === 1'b0, "R2 no output in first block", out_valid, 0);
        end else begin
            chk(out_valid === 1'b1, "R3 valid follows input", out_valid, 1);
            if (extremes)
                chk(out_data === exp_d, "R8 extreme byte", out_data, exp_d);
            else if (blk % 2 == 1)
                chk(out_data === exp_d, "R4 column read", out_data, exp_d);
            else
                chk(out_data === exp_d, "R5 row read", out_data, exp_d);
        end
        chk(out_first === exp_f, "R7 first marker", out_first, exp_f);
        last_out = out_data;
    endtask

    task automatic run_block(input int gap_pct, input int kind);
        int n;
        n = 0;
        while (n < 64) begin
            if (gap_pct > 0 && $urandom_range(99, 0) < gap_pct) begin
                push(1'b0, 8'($urandom), 1'b0);
            end else begin
                case (kind)
                    0: push(1'b1, 8'(n), 1'b0);
                    1: push(1'b1, (n % 3 == 0) ? 8'hFF : 8'h00, 1'b1);
                    default: push(1'b1, 8'($urandom), 1'b0);
                endcase
                n++;
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) begin
            prev_blk[i] = 8'h00;
            cur_blk[i]  = 8'h00;
        end
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset valid", out_valid, 0);
        chk(out_first === 1'b0, "R1 reset first", out_first, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 after reset valid", out_valid, 0);
        last_out = out_data;

        run_block(0, 0);      // block 0: directed ramp, no output (R2)
        run_block(25, 2);     // block 1: column read of ramp (R4)
        run_block(25, 2);     // block 2: row read (R5)
        // long stall in the middle of block 3 (R6)
        for (int n = 0; n < 30; n++) push(1'b1, 8'($urandom), 1'b0);
        for (int n = 0; n < 20; n++) push(1'b0, 8'($urandom), 1'b0);
        for (int n = 30; n < 64; n++) push(1'b1, 8'($urandom), 1'b0);
        run_block(0, 1);      // block 4: extremes (R8)
        run_block(10, 2);     // block 5: reads the extremes
        run_block(40, 2);
        run_block(25, 2);

        // mid-stream reset (R1)
        for (int n = 0; n < 10; n++) push(1'b1, 8'($urandom), 1'b0);
        rst = 1'b1;
        in_valid = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid === 1'b0, "R1 mid reset valid", out_valid, 0);
        chk(out_first === 1'b0, "R1 mid reset first", out_first, 0);
        in_valid = 1'b0;
        rst = 1'b0;
        acc = 0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 post reset valid", out_valid, 0);
        last_out = out_data;
        run_block(20, 2);     // R1: empty again, no output
        run_block(20, 2);
        run_block(0, 2);
        push(1'b0, 8'h00, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule